// File: doc/BRIEF.md
# Audio Sample Error Concealment Unit

This block sits behind the second stage of an error-correcting decoder in a disc audio path and hides samples that the decoder could not repair. Every 16-bit signed sample arrives on a strobe with a channel select and three status bits from the decoder. The block combines those status bits into a single bad-sample mark. A sample that is not marked leaves unchanged. A marked sample is replaced before it leaves.

Concealment depends on the surrounding samples. When a marked sample has good samples on both sides in its own channel, it is replaced by the floor of the mean of the previous output and the following input sample. When two or more samples in a row are marked, every one of them repeats the last output value. To see the following sample, each channel keeps one sample in a lookahead register. Output therefore trails input by exactly one sample of the same channel. Left and right channels interleave on the one input and keep fully separate state.

Top module: `sample_conceal`

## Requirements
- R1: A sample is marked bad when `dec_uncorr` is 1, or when `dec_c1_err` is 1 and `dec_fixed` is 0. Under any other combination it is good. A marked sample never leaves with its own value unless concealment yields that value.
- R2: A good sample leaves with its input value unchanged.
- R3: A marked sample is isolated when the previous output of its channel was not marked, the next input sample of its channel is good, and its channel has already output a good sample. Such a sample is replaced by (previous output + next sample) >>> 1. The sum uses 17 bits, so it cannot overflow, and the shift is arithmetic, rounding toward minus infinity.
- R4: When two or more consecutive samples of a channel are marked, each of them leaves as the last value that channel output.
- R5: The output for a sample appears with `out_valid` high for one clock. That clock is the one after the strobe of the next sample on the same channel. `out_ch` gives the channel. The first sample a channel receives after reset produces no output.
- R6: A marked sample that leaves before its channel has output any good sample leaves as zero.
- R7: Channel 0 (left) and channel 1 (right), selected by `in_ch`, keep separate lookahead, history and run state. Interleaving one channel's traffic does not change the other channel's results.
- R8: After reset, `out_valid` is 0 and `out_data` is 0.
- R9: While `in_valid` is 0, the block ignores all data, flag and channel inputs. No output appears, and no channel state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | 1 | Channel of the strobed sample (0 left, 1 right) |
| in_data | input | 16 | Signed sample |
| dec_c1_err | input | 1 | First-stage decoder flagged this symbol |
| dec_uncorr | input | 1 | Second-stage check found the word uncorrectable |
| dec_fixed | input | 1 | Second-stage check corrected this symbol |
| out_valid | output | 1 | Output strobe |
| out_ch | output | 1 | Channel of the output sample |
| out_data | output | 16 | Concealed or passed sample |

## Verification
Each channel holds four pieces of state: a lookahead slot, the last output value, a run counter and a history bit. A fault in any of them shows at the port on that channel's next strobe, one sample later at most. A wrong run count makes an isolated error come out held, or makes a run come out averaged. A wrong history bit makes the first errors after reset come out non-zero. State crossing between channels shows up as wrong values on interleaved traffic. The scenarios therefore use sequences whose averaged, held and passed results all differ, including negative values for the rounding direction and full-scale values for overflow.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      CONC_PASS   = 2'd0,
      CONC_INTERP = 2'd1,
      CONC_HOLD   = 2'd2
   } conc_mode_e;
endpackage

// File: rtl/sc_flag_decide.sv
module sc_flag_decide (
   input  logic c1_err,
   input  logic uncorr,
   input  logic fixed,
   output logic bad
);
   // R1: uncorrectable word, or first-stage suspect left unrepaired
   always_comb bad = uncorr | (c1_err & ~fixed);
endmodule

// File: rtl/sc_avg.sv
module sc_avg #(
   parameter int DATA_W = 16
) (
   input  logic signed [DATA_W-1:0] a,
   input  logic signed [DATA_W-1:0] b,
   output logic signed [DATA_W-1:0] avg
);
   localparam int SUM_W = DATA_W + 1;
   logic signed [SUM_W-1:0] sum;

   always_comb begin
      sum = SUM_W'(a) + SUM_W'(b);
      avg = sum[SUM_W-1:1];
   end
endmodule

// File: rtl/sc_chan_slot.sv
module sc_chan_slot #(
   parameter int DATA_W = 16,
   parameter int RUN_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic                     in_bad,
   output logic                     fire,
   output logic signed [DATA_W-1:0] conc_val
);
   import sc_pkg::*;

   localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

   logic signed [DATA_W-1:0] look_data;
   logic                     look_bad;
   logic                     look_full;
   logic signed [DATA_W-1:0] last_out;
   logic                     hist;
   logic [RUN_W-1:0]         run;
   logic signed [DATA_W-1:0] mean;
   conc_mode_e               mode;

   sc_avg #(.DATA_W(DATA_W)) u_avg (
      .a   (last_out),
      .b   (in_data),
      .avg (mean)
   );

   always_comb begin
      if (!look_bad)
         mode = CONC_PASS;
      else if (run == '0 && !in_bad && hist)
         mode = CONC_INTERP;
      else
         mode = CONC_HOLD;
   end

   always_comb begin
      unique case (mode)
         CONC_PASS:   conc_val = look_data;
         CONC_INTERP: conc_val = mean;
         default:     conc_val = last_out;
      endcase
   end

   assign fire = load & look_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         look_data <= '0;
         look_bad  <= 1'b0;
         look_full <= 1'b0;
         last_out  <= '0;
         hist      <= 1'b0;
         run       <= '0;
      end else if (load) begin
         look_data <= in_data;
         look_bad  <= in_bad;
         look_full <= 1'b1;
         if (look_full) begin
            last_out <= conc_val;
            hist     <= hist | ~look_bad;
            if (!look_bad)
               run <= '0;
            else if (run != RUN_MAX)
               run <= run + 1'b1;
         end
      end
   end

   assert_pass_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && look_full && !look_bad) |=> (last_out == $past(look_data)));

   assert_hold_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && look_full && look_bad && run != '0) |=> (last_out == $past(last_out)));

   assert_zero_nohist_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && look_full && look_bad && !hist) |=> (last_out == '0));

   assert_run_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && look_full && look_bad && run == RUN_MAX) |=> (run == RUN_MAX));

   assert_quiet_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(last_out) && $stable(look_data) && $stable(run)));
endmodule

// File: rtl/sample_conceal.sv
module sample_conceal #(
   parameter int DATA_W = 16,
   parameter int NUM_CH = 2,
   parameter int RUN_W  = 2,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [CH_W-1:0]          in_ch,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic                     dec_c1_err,
   input  logic                     dec_uncorr,
   input  logic                     dec_fixed,
   output logic                     out_valid,
   output logic [CH_W-1:0]          out_ch,
   output logic signed [DATA_W-1:0] out_data
);
   if (DATA_W < 2) begin : g_bad_width
      $error("sample_conceal: DATA_W must be at least 2");
   end
   if (NUM_CH < 2) begin : g_bad_ch
      $error("sample_conceal: NUM_CH must be at least 2");
   end
   if (RUN_W < 1) begin : g_bad_run
      $error("sample_conceal: RUN_W must be at least 1");
   end

   logic                     in_bad;
   logic [NUM_CH-1:0]        ch_load;
   logic [NUM_CH-1:0]        ch_fire;
   logic signed [DATA_W-1:0] ch_val [NUM_CH];
   logic                     sel_fire;
   logic signed [DATA_W-1:0] sel_val;

   sc_flag_decide u_flag (
      .c1_err (dec_c1_err),
      .uncorr (dec_uncorr),
      .fixed  (dec_fixed),
      .bad    (in_bad)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      assign ch_load[g] = in_valid && (in_ch == CH_W'(g));
      sc_chan_slot #(.DATA_W(DATA_W), .RUN_W(RUN_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ch_load[g]),
         .in_data  (in_data),
         .in_bad   (in_bad),
         .fire     (ch_fire[g]),
         .conc_val (ch_val[g])
      );
   end

   always_comb begin
      sel_fire = 1'b0;
      sel_val  = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (in_ch == CH_W'(i)) begin
            sel_fire = ch_fire[i];
            sel_val  = ch_val[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ch    <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= sel_fire;
         if (sel_fire) begin
            out_ch   <= in_ch;
            out_data <= sel_val;
         end
      end
   end

   assert_out_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_out_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ch == $past(in_ch)));

   assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));

   assert_single_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_load));
endmodule

// File: tb/tb_sample_conceal.sv
`timescale 1ns/1ps
module tb_sample_conceal;
   logic               clk = 1'b0;
   logic               rst_n;
   logic               in_valid;
   logic [0:0]         in_ch;
   logic signed [15:0] in_data;
   logic               dec_c1_err, dec_uncorr, dec_fixed;
   logic               out_valid;
   logic [0:0]         out_ch;
   logic signed [15:0] out_data;

   int checks = 0;
   int fails  = 0;
   logic               got_v;
   logic [0:0]         got_ch;
   logic signed [15:0] got_d;

   always #2.5 clk = ~clk;

   sample_conceal dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
      .in_data(in_data), .dec_c1_err(dec_c1_err), .dec_uncorr(dec_uncorr),
      .dec_fixed(dec_fixed), .out_valid(out_valid), .out_ch(out_ch),
      .out_data(out_data)
   );

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; in_ch = '0; in_data = '0;
      dec_c1_err = 1'b0; dec_uncorr = 1'b0; dec_fixed = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // flag code: 0 good, 1 uncorrectable, 2 c1 unrepaired, 3 c1 repaired (good)
   task automatic push(input bit ch, input int val, input int fc);
      @(negedge clk);
      in_valid   = 1'b1;
      in_ch      = ch;
      in_data    = 16'(val);
      dec_uncorr = (fc == 1);
      dec_c1_err = (fc == 2 || fc == 3);
      dec_fixed  = (fc == 3);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'h5a5a;
      got_v  = out_valid;
      got_d  = out_data;
      got_ch = out_ch;
   endtask

   task automatic expect_out(input string tag, input bit ev, input int ed, input bit ech);
      checks++;
      if (got_v !== ev || (ev && (got_d !== 16'(ed) || got_ch !== ech))) begin
         fails++;
         $display("FAIL %s: got v=%0b d=%0d ch=%0d, expected v=%0b d=%0d ch=%0d",
                  tag, got_v, got_d, got_ch, ev, 16'(ed), ech);
      end
   endtask

   task automatic t_reset();
      do_reset();
      checks++;
      if (out_valid !== 1'b0 || out_data !== 16'sd0) begin
         fails++;
         $display("FAIL R8: got v=%0b d=%0d, expected v=0 d=0", out_valid, out_data);
      end
   endtask

   task automatic t_pass();
      do_reset();
      push(0, 100, 0); expect_out("R5 first sample silent", 0, 0, 0);
      push(0, 200, 0); expect_out("R2 pass 100", 1, 100, 0);
      push(0, -300, 0); expect_out("R2 pass 200", 1, 200, 0);
      push(0, 5, 0);  expect_out("R2 pass -300", 1, -300, 0);
   endtask

   task automatic t_flag();
      do_reset();
      push(0, 1000, 0);
      push(0, 555, 3);  expect_out("R2 good 1000", 1, 1000, 0);
      push(0, 2000, 0); expect_out("R1 c1 repaired passes", 1, 555, 0);
      push(0, 777, 2);  expect_out("R2 good 2000", 1, 2000, 0);
      push(0, 3000, 0); expect_out("R1 c1 unrepaired concealed", 1, 2500, 0);
      push(0, 888, 1);  expect_out("R2 good 3000", 1, 3000, 0);
      push(0, 4000, 0); expect_out("R1 uncorrectable concealed", 1, 3500, 0);
      push(0, 4100, 0); expect_out("R2 good 4000", 1, 4000, 0);
   endtask

   task automatic t_interp();
      do_reset();
      push(0, -100, 0);
      push(0, 9, 1);    expect_out("R2 good -100", 1, -100, 0);
      push(0, -201, 0); expect_out("R3 floor of negative mean", 1, -151, 0);
      push(0, 0, 0);    expect_out("R2 good -201", 1, -201, 0);
      do_reset();
      push(0, 32767, 0);
      push(0, -1, 1);
      push(0, 32767, 0);
      push(0, 0, 0);    expect_out("R3 full scale no overflow", 1, 32767, 0);
   endtask

   task automatic t_hold();
      do_reset();
      push(0, 50, 0);
      push(0, 1, 1);  expect_out("R2 good 50", 1, 50, 0);
      push(0, 2, 2);  expect_out("R4 run start held", 1, 50, 0);
      push(0, 3, 1);  expect_out("R4 run mid held", 1, 50, 0);
      push(0, 60, 0); expect_out("R4 run end held", 1, 50, 0);
      push(0, 70, 0); expect_out("R2 good 60 after run", 1, 60, 0);
      push(0, 4, 1);  expect_out("R2 good 70", 1, 70, 0);
      push(0, 80, 0); expect_out("R3 isolated after run", 1, 75, 0);
      push(0, 90, 0); expect_out("R2 good 80", 1, 80, 0);
   endtask

   task automatic t_nohist();
      do_reset();
      push(0, 123, 1);
      push(0, 5, 2);  expect_out("R6 first bad zero", 1, 0, 0);
      push(0, 40, 0); expect_out("R6 second bad zero", 1, 0, 0);
      push(0, 41, 0); expect_out("R2 good 40", 1, 40, 0);
      do_reset();
      push(0, 9, 1);
      push(0, 20, 0); expect_out("R6 isolated without history zero", 1, 0, 0);
      push(0, 21, 0); expect_out("R2 good 20", 1, 20, 0);
   endtask

   task automatic t_chan();
      do_reset();
      push(0, 10, 0);   expect_out("R7 left first silent", 0, 0, 0);
      push(1, 1000, 0); expect_out("R7 right first silent", 0, 0, 1);
      push(0, 1, 1);    expect_out("R7 left 10", 1, 10, 0);
      push(1, 2000, 0); expect_out("R7 right 1000", 1, 1000, 1);
      push(0, 30, 0);   expect_out("R7 left interp", 1, 20, 0);
      push(1, 2, 1);    expect_out("R7 right 2000", 1, 2000, 1);
      push(0, 40, 0);   expect_out("R7 left 30", 1, 30, 0);
      push(1, 3, 2);    expect_out("R7 right hold a", 1, 2000, 1);
      push(1, 3000, 0); expect_out("R7 right hold b", 1, 2000, 1);
      push(0, 50, 0);   expect_out("R7 left 40 unaffected", 1, 40, 0);
   endtask

   task automatic t_idle();
      do_reset();
      push(0, 11, 0);
      push(0, 12, 0); expect_out("R2 good 11", 1, 11, 0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         in_ch = 1'(k); in_data = 16'(k * 777 - 2000);
         dec_uncorr = k[0]; dec_c1_err = k[1]; dec_fixed = 1'b0;
         checks++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9: got out_valid=%0b, expected 0", out_valid);
         end
      end
      push(0, 13, 0); expect_out("R9 lookahead kept while idle", 1, 12, 0);
   endtask

   initial begin
      #1_000_000;
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_pass();
      t_flag();
      t_interp();
      t_hold();
      t_nohist();
      t_chan();
      t_idle();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule